// File: doc/BRIEF.md
# Bus-Read DMA Burst Controller

This block moves one block of data from a bus address into a local input FIFO by acting as the initiator of read bursts on a simplified PCI-style bus. A descriptor gives it four things: a byte address on the bus, a byte count, a flag that picks an I/O read instead of a memory read, and a flag that reverses the byte order of each word. The block waits until the FIFO has enough room and then raises a bus request. Once granted, it drives data phases until a stop condition ends the burst. It then waits for room again, re-arbitrates, and resumes from the last accepted phase. When the count reaches zero it reports completion.

A burst ends when any one of these happens: the target ends it, the room reserved at grant time runs out, the count runs out, the data-phase limit is reached, or the latency timer expires after the grant has been removed. A target abort ends the whole operation and raises an error.

Top module: `busrd_dma_ctrl`

## Requirements
- R1: `bus_req` rises only on the clock edge after the controller, while waiting, has seen `fifo_free` of at least 16 words. While `fifo_free` is below 16, no request is made.
- R2: A requested count above 16384 bytes is reduced to 16384. A zero count finishes at once: `done` is high in the cycle after `desc_start`, and there is no bus activity.
- R3: `bus_cmd` is 4'b0110 for a memory read and 4'b0010 for an I/O read (`desc_io`=1). Both kinds use the same address sequence.
- R4: The first data phase of the operation carries the exact start byte address, which may be unaligned. Every later phase carries the next word-aligned address, which is 4 higher. After a burst stops early, the next burst resumes at the address following the last accepted phase.
- R5: Bit i of `bus_be` (and of `fifo_wbe`) marks byte lane i. A phase enables the lanes from the address offset upward, and only as many lanes as bytes remain.
- R6: With `desc_swap`=1, byte lane i of `fifo_wdata` holds lane 3-i of `bus_data`. Otherwise the data passes through unchanged.
- R7: A burst stops when the target asserts `bus_term` (a phase acknowledged in that same cycle is kept). It also stops when the number of accepted phases equals the `fifo_free` value sampled at grant.
- R8: A burst stops when its accepted phases reach `max_phases`. A value of 0 means 256.
- R9: The latency timer is loaded from `lat_init` at grant and counts down once per burst cycle. The burst stops in the first cycle where the timer is 0 and `bus_gnt` is low.
- R10: `done` pulses for one cycle after the phase that exhausts the count. `done_flag` then stays high and `busy` is low, until the next start.
- R11: `bus_abort` ends the operation. The phase in that cycle is not written, `error` goes high and `busy` goes low on the next cycle.
- R12: `desc_start` while `busy` is high is ignored.
- R13: `bus_frame` rises on the cycle after a grant is seen during a request. It falls on the cycle after a stop. `fifo_wr` pulses on the cycle after each accepted phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_start | input | 1 | Start pulse with descriptor |
| desc_addr | input | 32 | Starting bus byte address |
| desc_bytes | input | 15 | Byte count |
| desc_io | input | 1 | 1 selects I/O read |
| desc_swap | input | 1 | 1 reverses bytes in each word |
| max_phases | input | 8 | Data-phase limit per burst, 0 = 256 |
| lat_init | input | 8 | Latency timer load value |
| fifo_free | input | 9 | Free words in the input FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_wbe | output | 4 | Valid byte lanes of the written word |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_frame | output | 1 | Burst in progress |
| bus_cmd | output | 4 | Bus command code |
| bus_addr | output | 32 | Address of the current phase |
| bus_be | output | 4 | Byte enables of the current phase |
| bus_ack | input | 1 | Target accepts the current phase |
| bus_data | input | 32 | Read data |
| bus_term | input | 1 | Target ends the burst |
| bus_abort | input | 1 | Target abort |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| done_flag | output | 1 | Sticky completion status |
| error | output | 1 | Sticky abort status |

## Verification
A wrong address or remaining-count register shows up in the very next data phase, as a mismatch in `bus_addr` or `bus_be`. A wrong swap or lane mux shows in `fifo_wdata` one cycle after the phase. A faulty phase, credit or timer counter shows as `bus_frame` staying high, or falling, one cycle off from the bench's own count of the stop conditions. A broken count or abort path shows as `done` or `error` missing, or coming late, by the cycle after the final phase.

// File: rtl/busrd_pkg.sv
package busrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_REQ   = 2'd2,
    ST_BURST = 2'd3
  } busrd_st_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
endpackage

// File: rtl/busrd_lane.sv
// Per-phase byte lane logic: byte enables, byte count of the phase, optional swap.
module busrd_lane #(
  parameter int DW    = 32,
  parameter int CNT_W = 15,
  localparam int BYTES = DW / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] cnt,
  input  logic             swap,
  input  logic [DW-1:0]    din,
  output logic [BYTES-1:0] be,
  output logic [OFF_W:0]   nbytes,
  output logic [DW-1:0]    dout
);
  logic [OFF_W:0] avail;

  always_comb begin
    avail = (OFF_W+1)'(BYTES) - {1'b0, off};
    if (cnt < CNT_W'(avail)) nbytes = cnt[OFF_W:0];
    else                     nbytes = avail;
  end

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      be[i] = (i >= int'(off)) && (i < int'(off) + int'(nbytes));
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign dout[8*g +: 8] = swap ? din[8*(BYTES-1-g) +: 8] : din[8*g +: 8];
  end
endmodule

// File: rtl/busrd_limits.sv
// Burst limit tracking: data-phase limit, FIFO credit, latency timer.
module busrd_limits #(
  parameter int PH_W   = 8,
  parameter int LT_W   = 8,
  parameter int FREE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic              acc,
  input  logic [PH_W-1:0]   max_phases,
  input  logic [LT_W-1:0]   lat_init,
  input  logic [FREE_W-1:0] free_words,
  input  logic              gnt,
  output logic              lim_hit,
  output logic              lt_expired
);
  logic [PH_W-1:0]   ph_q;
  logic [FREE_W-1:0] cr_q;
  logic [LT_W-1:0]   lt_q;
  logic [PH_W-1:0]   ph_n;
  logic [FREE_W-1:0] cr_n;

  assign ph_n       = ph_q + 1'b1;
  assign cr_n       = cr_q - 1'b1;
  assign lim_hit    = acc && ((ph_n == max_phases) || (cr_n == '0));
  assign lt_expired = run && (lt_q == '0) && !gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      cr_q <= '0;
      lt_q <= '0;
    end else if (load) begin
      ph_q <= '0;
      cr_q <= free_words;
      lt_q <= lat_init;
    end else if (run) begin
      if (acc) begin
        ph_q <= ph_n;
        cr_q <= cr_n;
      end
      if (lt_q != '0) lt_q <= lt_q - 1'b1;
    end
  end

  // R7: an accepted phase always has reserved FIFO room left
  a_r7_credit_left: assert property (@(posedge clk) disable iff (rst)
    acc |-> (cr_q != '0));
  // R9: the timer never counts while no burst runs
  a_r9_timer_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !load && !$past(load) && !$past(run)) |=> $stable(lt_q));
endmodule

// File: rtl/busrd_dma_ctrl.sv
module busrd_dma_ctrl #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_BYTES = 16384,
  parameter int CNT_W     = $clog2(MAX_BYTES) + 1,
  parameter int FREE_W    = 9,
  parameter int START_ROOM = 16,
  parameter int PH_W      = 8,
  parameter int LT_W      = 8,
  localparam int BYTES    = DW / 8,
  localparam int OFF_W    = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_start,
  input  logic [AW-1:0]     desc_addr,
  input  logic [CNT_W-1:0]  desc_bytes,
  input  logic              desc_io,
  input  logic              desc_swap,
  input  logic [PH_W-1:0]   max_phases,
  input  logic [LT_W-1:0]   lat_init,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_wr,
  output logic [DW-1:0]     fifo_wdata,
  output logic [BYTES-1:0]  fifo_wbe,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_frame,
  output logic [3:0]        bus_cmd,
  output logic [AW-1:0]     bus_addr,
  output logic [BYTES-1:0]  bus_be,
  input  logic              bus_ack,
  input  logic [DW-1:0]     bus_data,
  input  logic              bus_term,
  input  logic              bus_abort,
  output logic              busy,
  output logic              done,
  output logic              done_flag,
  output logic              error
);
  import busrd_pkg::*;

  busrd_st_t         st_q;
  logic [AW-1:0]     addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              io_q;
  logic              swap_q;

  logic [BYTES-1:0]  lane_be;
  logic [OFF_W:0]    lane_nb;
  logic [DW-1:0]     lane_data;
  logic [CNT_W-1:0]  cnt_n;
  logic [CNT_W-1:0]  start_cnt;
  logic              acc;
  logic              grant_edge;
  logic              lim_hit;
  logic              lt_expired;
  logic              stop;

  busrd_lane #(.DW(DW), .CNT_W(CNT_W)) u_lane (
    .off    (addr_q[OFF_W-1:0]),
    .cnt    (cnt_q),
    .swap   (swap_q),
    .din    (bus_data),
    .be     (lane_be),
    .nbytes (lane_nb),
    .dout   (lane_data)
  );

  assign acc        = (st_q == ST_BURST) && bus_ack && !bus_abort;
  assign grant_edge = (st_q == ST_REQ) && bus_gnt;

  busrd_limits #(.PH_W(PH_W), .LT_W(LT_W), .FREE_W(FREE_W)) u_limits (
    .clk        (clk),
    .rst        (rst),
    .load       (grant_edge),
    .run        (st_q == ST_BURST),
    .acc        (acc),
    .max_phases (max_phases),
    .lat_init   (lat_init),
    .free_words (fifo_free),
    .gnt        (bus_gnt),
    .lim_hit    (lim_hit),
    .lt_expired (lt_expired)
  );

  assign cnt_n     = cnt_q - CNT_W'(lane_nb);
  assign stop      = bus_term || lt_expired || lim_hit;
  assign start_cnt = (desc_bytes > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : desc_bytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      cnt_q      <= '0;
      io_q       <= 1'b0;
      swap_q     <= 1'b0;
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      fifo_wbe   <= '0;
      done       <= 1'b0;
      done_flag  <= 1'b0;
      error      <= 1'b0;
    end else begin
      fifo_wr <= 1'b0;
      done    <= 1'b0;
      case (st_q)
        ST_IDLE: if (desc_start) begin
          addr_q    <= desc_addr;
          cnt_q     <= start_cnt;
          io_q      <= desc_io;
          swap_q    <= desc_swap;
          error     <= 1'b0;
          done_flag <= 1'b0;
          if (start_cnt == '0) begin
            done      <= 1'b1;
            done_flag <= 1'b1;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (fifo_free >= FREE_W'(START_ROOM)) st_q <= ST_REQ;
        ST_REQ:  if (bus_gnt) st_q <= ST_BURST;
        ST_BURST: begin
          if (acc) begin
            addr_q     <= {addr_q[AW-1:OFF_W], {OFF_W{1'b0}}} + AW'(BYTES);
            cnt_q      <= cnt_n;
            fifo_wr    <= 1'b1;
            fifo_wdata <= lane_data;
            fifo_wbe   <= lane_be;
          end
          if (bus_abort) begin
            st_q  <= ST_IDLE;
            error <= 1'b1;
          end else if (acc && cnt_n == '0) begin
            st_q      <= ST_IDLE;
            done      <= 1'b1;
            done_flag <= 1'b1;
          end else if (stop) begin
            st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = (st_q == ST_REQ) || (st_q == ST_BURST);
  assign bus_frame = (st_q == ST_BURST);
  assign bus_addr  = addr_q;
  assign bus_be    = bus_frame ? lane_be : '0;
  assign bus_cmd   = io_q ? CMD_IO_RD : CMD_MEM_RD;

  // R1: a request is raised only after enough FIFO room was seen
  a_r1_room_before_req: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(fifo_free) >= FREE_W'(START_ROOM)));
  // R2: the remaining count never exceeds the cap
  a_r2_count_capped: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= CNT_W'(MAX_BYTES)));
  // R4: phases after an accepted one are word aligned
  a_r4_aligned_after_acc: assert property (@(posedge clk) disable iff (rst)
    (bus_frame && $past(bus_frame && bus_ack && !bus_abort)) |-> (bus_addr[OFF_W-1:0] == '0));
  // R5: every phase of a burst enables at least one lane
  a_r5_lanes_present: assert property (@(posedge clk) disable iff (rst)
    bus_frame |-> (bus_be != '0));
  // R10: completion leaves nothing to move
  a_r10_done_empty: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cnt_q == '0));
  // R11: an abort ends the operation with an error
  a_r11_abort_ends: assert property (@(posedge clk) disable iff (rst)
    $past(bus_frame && bus_abort) |-> (error && !busy));
endmodule

// File: tb/busrd_dma_ctrl_tb.sv
`timescale 1ns/100ps
module busrd_dma_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        desc_start;
  logic [31:0] desc_addr;
  logic [14:0] desc_bytes;
  logic        desc_io, desc_swap;
  logic [7:0]  max_phases, lat_init;
  logic [8:0]  fifo_free;
  logic        fifo_wr;
  logic [31:0] fifo_wdata;
  logic [3:0]  fifo_wbe;
  logic        bus_req, bus_gnt, bus_frame;
  logic [3:0]  bus_cmd;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_ack;
  logic [31:0] bus_data;
  logic        bus_term, bus_abort;
  logic        busy, done, done_flag, error;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  busrd_dma_ctrl u_dut (
    .clk(clk), .rst(rst), .desc_start(desc_start), .desc_addr(desc_addr),
    .desc_bytes(desc_bytes), .desc_io(desc_io), .desc_swap(desc_swap),
    .max_phases(max_phases), .lat_init(lat_init), .fifo_free(fifo_free),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_wbe(fifo_wbe),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_frame(bus_frame),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_ack(bus_ack), .bus_data(bus_data), .bus_term(bus_term),
    .bus_abort(bus_abort), .busy(busy), .done(done),
    .done_flag(done_flag), .error(error)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic int nb_of(input int off, input int cnt);
    return (cnt < 4 - off) ? cnt : 4 - off;
  endfunction

  function automatic logic [3:0] be_of(input int off, input int cnt);
    logic [3:0] b;
    for (int i = 0; i < 4; i++) b[i] = (i >= off) && (i < off + nb_of(off, cnt));
    return b;
  endfunction

  task automatic idle_bus();
    bus_gnt = 0; bus_ack = 0; bus_term = 0; bus_abort = 0;
  endtask

  task automatic run_op(input logic [31:0] a, input int c, input bit io, input bit sw,
                        input int fr, input int mb, input int lt, input int ackp,
                        input int termp, input bit dropg, input int abort_at, input bit poke);
    int mcnt, k, ph, cred, nacc, cyc, off, n;
    logic [31:0] maddr, ew;
    logic [3:0] ebe, ewbe;
    bit exp_wr, must_frame, must_nof, fin, exp_done, exp_err, poked, stp, acc;
    max_phases = mb[7:0]; lat_init = lt[7:0]; fifo_free = fr[8:0];
    @(negedge clk);
    desc_addr = a; desc_bytes = c[14:0]; desc_io = io; desc_swap = sw; desc_start = 1;
    @(negedge clk);
    desc_start = 0;
    mcnt = (c > 16384) ? 16384 : c;
    maddr = a;
    if (mcnt == 0) begin
      chk(done && done_flag && !busy && !bus_req, "R2 zero count done", {28'd0, done, done_flag, busy, bus_req}, 32'hC);
      @(negedge clk);
      chk(!done && done_flag && !bus_frame, "R10 done single pulse", {30'd0, done, bus_frame}, 0);
      return;
    end
    chk(busy && !done_flag, "R10 busy after start", {30'd0, busy, done_flag}, 32'h2);
    exp_wr = 0; must_frame = 0; must_nof = 0; fin = 0; exp_done = 0; exp_err = 0;
    poked = 0; nacc = 0; cyc = 0; k = 0; ph = 0; cred = 0; ew = 0; ewbe = 0;
    while (!fin && cyc < 60000) begin
      cyc++;
      desc_start = 0;
      if (exp_wr) chk(fifo_wr && fifo_wdata == ew && fifo_wbe == ewbe, "R13 R6 R5 fifo write", fifo_wdata, ew);
      else        chk(!fifo_wr, "R13 no spurious write", {31'd0, fifo_wr}, 0);
      exp_wr = 0;
      if (exp_done) begin
        chk(done && done_flag && !busy, "R10 done after last phase", {29'd0, done, done_flag, busy}, 32'h6);
        fin = 1;
      end else if (exp_err) begin
        chk(error && !busy && !fifo_wr, "R11 abort error", {29'd0, error, busy, fifo_wr}, 32'h4);
        fin = 1;
      end else begin
        if (must_frame) chk(bus_frame, "R13 frame after grant", {31'd0, bus_frame}, 1);
        if (must_nof)   chk(!bus_frame, "R7 R8 R9 burst stop", {31'd0, bus_frame}, 0);
        must_frame = 0; must_nof = 0;
        if (bus_frame) begin
          off = int'(maddr[1:0]);
          ebe = be_of(off, mcnt);
          chk(bus_addr == maddr, "R4 phase address", bus_addr, maddr);
          chk(bus_be == ebe, "R5 byte enables", {28'd0, bus_be}, {28'd0, ebe});
          chk(bus_cmd == (io ? 4'b0010 : 4'b0110), "R3 command", {28'd0, bus_cmd}, io ? 32'h2 : 32'h6);
          bus_gnt   = !(dropg && k >= 1);
          bus_data  = $urandom;
          bus_ack   = ($urandom % 100) < ackp;
          bus_term  = ($urandom % 100) < termp;
          bus_abort = (abort_at >= 0) && (nacc == abort_at);
          if (poke && nacc == 3 && !poked) begin
            desc_start = 1; desc_addr = 32'h0; desc_bytes = 15'd4; poked = 1;
          end
          acc = bus_ack && !bus_abort;
          stp = bus_term || (k >= lt && !bus_gnt);
          if (bus_abort) exp_err = 1;
          else begin
            if (acc) begin
              n = nb_of(off, mcnt);
              ew = sw ? bswap(bus_data) : bus_data;
              ewbe = ebe; exp_wr = 1;
              mcnt -= n;
              maddr = {maddr[31:2], 2'b00} + 32'd4;
              ph = (ph + 1) % 256; cred--; nacc++;
              if (ph == mb || cred == 0) stp = 1;
            end
            if (acc && mcnt == 0) exp_done = 1;
            else if (stp) must_nof = 1;
          end
          k++;
        end else begin
          idle_bus();
          if (bus_req) begin
            chk(fifo_free >= 16, "R1 request with room", {23'd0, fifo_free}, 16);
            bus_gnt = 1; cred = int'(fifo_free); must_frame = 1; k = 0; ph = 0;
          end else if (fr < 16) begin
            if (cyc == 20) fifo_free = 9'd16;
          end
        end
      end
      if (!fin) @(negedge clk);
    end
    idle_bus();
    if (!fin) chk(0, "R10 operation never ended", 0, 1);
    @(negedge clk);
    if (exp_done) chk(!done && done_flag, "R10 done single pulse", {30'd0, done, done_flag}, 1);
    else          chk(error && !done_flag && !bus_req, "R11 error held", {29'd0, error, done_flag, bus_req}, 32'h4);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; desc_start = 0; desc_addr = 0; desc_bytes = 0; desc_io = 0; desc_swap = 0;
    max_phases = 0; lat_init = 0; fifo_free = 0; bus_data = 0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !bus_req && !bus_frame && !fifo_wr && !done && !done_flag && !error,
        "R10 reset state", {25'd0, busy, bus_req, bus_frame, fifo_wr, done, done_flag, error}, 0);
    // R2 zero count
    run_op(32'h100, 0, 0, 0, 40, 0, 8, 100, 0, 0, -1, 0);
    // R4 R5 aligned memory read
    run_op(32'h2000, 64, 0, 0, 40, 0, 8, 100, 0, 0, -1, 0);
    // R3 R5 R6 unaligned I/O read with swap
    run_op(32'h1003, 23, 1, 1, 40, 0, 8, 100, 0, 0, -1, 0);
    run_op(32'h4001, 2, 0, 1, 40, 0, 8, 80, 0, 0, -1, 0);
    // R7 credit stop at 16 words
    run_op(32'h3000, 200, 0, 0, 16, 0, 200, 100, 0, 0, -1, 0);
    // R8 phase limit of 5
    run_op(32'h5002, 100, 0, 0, 100, 5, 200, 100, 0, 0, -1, 0);
    // R9 latency expiry with grant removed
    run_op(32'h6000, 256, 0, 0, 300, 0, 3, 100, 0, 1, -1, 0);
    run_op(32'h6100, 64, 1, 0, 300, 0, 0, 100, 0, 1, -1, 0);
    // R7 target termination
    run_op(32'h7003, 300, 0, 1, 60, 0, 200, 90, 20, 0, -1, 0);
    // R11 abort
    run_op(32'h8000, 128, 0, 0, 60, 0, 200, 100, 0, 0, 4, 0);
    // R1 low room wait
    run_op(32'h9000, 80, 0, 0, 8, 0, 200, 100, 0, 0, -1, 0);
    // R12 start while busy
    run_op(32'hA002, 120, 1, 0, 60, 0, 200, 100, 0, 0, -1, 1);
    // R2 R8 clip to 16384 with 256-phase bursts
    run_op(32'hB000, 20000, 0, 0, 300, 0, 255, 100, 0, 0, -1, 0);
    for (int t = 0; t < 10; t++) begin
      run_op($urandom, 1 + ($urandom % 700), $urandom % 2, $urandom % 2,
             16 + ($urandom % 100), $urandom % 20, $urandom % 40,
             50 + ($urandom % 51), $urandom % 10, $urandom % 2, -1, 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule